// File: doc/BRIEF.md
# Audio Link Dock Sequencer

This block sits on the controller side of a serial audio link and decides when a docking-station codec is electrically joined to the link and when it is cut away again. Software owns one control bit, the attach request, and reads one status bit, the mate flag. The sequencer watches the platform reset, the link controller reset and the sampled levels of the link bit clock, SYNC and SDO lines. It drives two active-low outputs: a dock isolation enable and a reset for the dock codec.

After the link reset is released with the attach request set, the sequencer first joins the dock to the link and only later lets the dock codec out of reset. It waits a fixed number of bit-clock rising edges between the two so that the link keepers can settle. When software drops the attach request, the dock codec reset is re-applied on a bit-clock rising edge. The dock is isolated again only after a minimum number of further bit-clock rising edges, and only in a cycle where the bit clock, SYNC and SDO are all low. The mate flag reports a completed dock and clears once isolation is done.

All logic runs on one fast system clock. The bit clock and the link lines arrive as levels sampled in that domain, and a bit-clock edge is a 0-to-1 change seen between two system clocks.

Top module: `dock_seq`

## Requirements
- R1: A platform reset (`rst` high) clears the attach bit and the mate flag, de-asserts the dock enable (`dock_en_n` = 1) and asserts the dock codec reset (`dock_rst_n` = 0).
- R2: While `link_rst` is high, `dock_en_n` stays 1 and `dock_rst_n` stays 0 whatever the attach bit holds and whatever the bit clock does.
- R3: With `link_rst` low, the attach bit at 1 and the sequencer isolated, `dock_en_n` goes to 0 on the next clock while `dock_rst_n` stays 0.
- R4: `dock_rst_n` goes to 1 on the clock that detects the SETTLE-th bit-clock rising edge after the enable asserted (default SETTLE = 8), and the mate flag goes to 1 on that same clock.
- R5: Clearing the attach bit while docked leaves the outputs unchanged until a bit-clock rising edge. On the clock that detects that edge `dock_rst_n` goes to 0, while `dock_en_n` stays 0 and the mate flag stays 1.
- R6: During undocking, `dock_en_n` returns to 1 only after at least MIN_ISO (default 4) further bit-clock rising edges, and only on a clock whose sampled bit clock, SYNC and SDO are all 0. The mate flag clears on that same clock.
- R7: Setting the attach bit again during undocking does not shorten it. Once isolation has completed and the mate flag is 0, `dock_en_n` goes back to 0 on the following clock.
- R8: `link_rst` going high in any state forces, on the next clock, `dock_en_n` = 1, `dock_rst_n` = 0 and mate flag = 0.
- R9: `dock_rst_n` is never 1 while `dock_en_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Platform reset, synchronous, active high |
| link_rst | input | 1 | Link controller reset, active high |
| attach_wr | input | 1 | Write strobe for the attach bit |
| attach_wdata | input | 1 | Value written to the attach bit |
| bclk_lvl | input | 1 | Sampled level of the link bit clock |
| sync_lvl | input | 1 | Sampled level of the link SYNC line |
| sdo_lvl | input | 1 | Sampled level of the link SDO line |
| attach_o | output | 1 | Current attach bit |
| mate_o | output | 1 | Mate flag: 1 when the dock is mated |
| dock_en_n | output | 1 | Dock isolation enable, active low |
| dock_rst_n | output | 1 | Dock codec reset, active low |

## Verification
The docking phase is driven one bit-clock edge at a time, and the codec reset is checked after every edge, so a release one edge early or late cannot pass. The undocking phase is swept in two ways. Idle-low windows are offered after each of the first three edges, which shows whether the minimum edge count is enforced. After that minimum, all eight combinations of bit clock, SYNC and SDO are stepped through, which shows that isolation waits for the one all-low combination. Re-attach during undock, link reset while docked, link reset held with attach set, and a platform reset mid-dock each check a separate path back to the isolated state.

// File: rtl/dock_seq_pkg.sv
package dock_seq_pkg;

    typedef enum logic [1:0] {
        ST_ISOLATED = 2'd0,
        ST_POWERUP  = 2'd1,
        ST_DOCKED   = 2'd2,
        ST_RELEASE  = 2'd3
    } dock_state_e;

    typedef struct packed {
        logic bclk;
        logic sync;
        logic sdo;
    } link_lvl_t;

    function automatic int unsigned edge_cnt_w(input int unsigned a, input int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m < 1) ? 1 : $clog2(m + 1);
    endfunction

endpackage

// File: rtl/dock_attach_reg.sv
module dock_attach_reg (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic wdata,
    output logic attach
);
    always_ff @(posedge clk) begin
        if (rst)     attach <= 1'b0;
        else if (wr) attach <= wdata;
    end
endmodule

// File: rtl/dock_link_edge.sv
module dock_link_edge
    import dock_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  link_lvl_t lvl,
    output logic      bclk_rise,
    output logic      all_low
);
    logic bclk_q;

    always_ff @(posedge clk) begin
        if (rst) bclk_q <= 1'b0;
        else     bclk_q <= lvl.bclk;
    end

    assign bclk_rise = lvl.bclk & ~bclk_q;
    assign all_low   = ~(lvl.bclk | lvl.sync | lvl.sdo);
endmodule

// File: rtl/dock_edge_counter.sv
module dock_edge_counter #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr)                 cnt <= '0;
        else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dock_seq_fsm.sv
module dock_seq_fsm
    import dock_seq_pkg::*;
#(
    parameter int unsigned SETTLE  = 8,
    parameter int unsigned MIN_ISO = 4,
    parameter int unsigned CW      = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          link_rst,
    input  logic          attach,
    input  logic          bclk_rise,
    input  logic          all_low,
    input  logic [CW-1:0] cnt,
    output logic          cnt_clr,
    output logic          mate,
    output logic          dock_en_n,
    output logic          dock_rst_n
);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE - 1);
    localparam logic [CW-1:0] ISO_MIN     = CW'(MIN_ISO);

    dock_state_e state, nxt;

    always_comb begin
        nxt = state;
        if (link_rst) begin
            nxt = ST_ISOLATED;
        end else begin
            unique case (state)
                ST_ISOLATED: if (attach) nxt = ST_POWERUP;
                ST_POWERUP: begin
                    if (!attach)                                nxt = ST_RELEASE;
                    else if (bclk_rise && cnt == SETTLE_LAST)   nxt = ST_DOCKED;
                end
                ST_DOCKED:   if (!attach && bclk_rise) nxt = ST_RELEASE;
                ST_RELEASE:  if (cnt >= ISO_MIN && all_low) nxt = ST_ISOLATED;
                default:     nxt = ST_ISOLATED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_ISOLATED;
            mate  <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt == ST_ISOLATED)   mate <= 1'b0;
            else if (nxt == ST_DOCKED) mate <= 1'b1;
        end
    end

    assign cnt_clr    = (nxt != state);
    assign dock_en_n  = (state == ST_ISOLATED);
    assign dock_rst_n = (state == ST_DOCKED);
endmodule

// File: rtl/dock_seq.sv
module dock_seq
    import dock_seq_pkg::*;
#(
    parameter int unsigned SETTLE  = 8,
    parameter int unsigned MIN_ISO = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic link_rst,
    input  logic attach_wr,
    input  logic attach_wdata,
    input  logic bclk_lvl,
    input  logic sync_lvl,
    input  logic sdo_lvl,
    output logic attach_o,
    output logic mate_o,
    output logic dock_en_n,
    output logic dock_rst_n
);
    localparam int unsigned CW = edge_cnt_w(SETTLE, MIN_ISO);

    link_lvl_t     lvl;
    logic          bclk_rise, all_low, cnt_clr;
    logic [CW-1:0] cnt;

    assign lvl = '{bclk: bclk_lvl, sync: sync_lvl, sdo: sdo_lvl};

    dock_attach_reg attach_i (
        .clk(clk), .rst(rst), .wr(attach_wr), .wdata(attach_wdata), .attach(attach_o)
    );

    dock_link_edge edge_i (
        .clk(clk), .rst(rst), .lvl(lvl), .bclk_rise(bclk_rise), .all_low(all_low)
    );

    dock_edge_counter #(.CW(CW)) cnt_i (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(bclk_rise), .cnt(cnt)
    );

    dock_seq_fsm #(.SETTLE(SETTLE), .MIN_ISO(MIN_ISO), .CW(CW)) fsm_i (
        .clk(clk), .rst(rst), .link_rst(link_rst), .attach(attach_o),
        .bclk_rise(bclk_rise), .all_low(all_low), .cnt(cnt), .cnt_clr(cnt_clr),
        .mate(mate_o), .dock_en_n(dock_en_n), .dock_rst_n(dock_rst_n)
    );
endmodule

// File: rtl/dock_seq_chk.sv
module dock_seq_chk #(
    parameter int unsigned MIN_ISO = 4
) (
    input logic clk,
    input logic rst,
    input logic link_rst,
    input logic bclk_lvl,
    input logic sync_lvl,
    input logic sdo_lvl,
    input logic attach_o,
    input logic mate_o,
    input logic dock_en_n,
    input logic dock_rst_n
);
    localparam int unsigned KW = $clog2(MIN_ISO + 1);
    localparam logic [KW-1:0] K_MIN = KW'(MIN_ISO);

    logic          bclk_prev;
    logic [KW-1:0] rise_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_prev <= 1'b0;
            rise_cnt  <= '0;
        end else begin
            bclk_prev <= bclk_lvl;
            if (dock_rst_n)                              rise_cnt <= '0;
            else if (bclk_lvl && !bclk_prev && rise_cnt != K_MIN) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (dock_en_n && !dock_rst_n && !mate_o && !attach_o));

    a_r8_link_reset_forces: assert property (@(posedge clk) disable iff (rst)
        link_rst |=> (dock_en_n && !dock_rst_n && !mate_o));

    a_r4_mate_with_release: assert property (@(posedge clk) disable iff (rst)
        $rose(dock_rst_n) |-> $rose(mate_o));

    a_r5_reset_on_bclk_edge: assert property (@(posedge clk) disable iff (rst)
        ($fell(dock_rst_n) && !$past(link_rst) && !$past(rst) && !$past(rst, 2))
        |-> ($past(bclk_lvl) && !$past(bclk_lvl, 2) && !dock_en_n && mate_o));

    a_r6_isolate_all_low: assert property (@(posedge clk) disable iff (rst)
        ($rose(dock_en_n) && !$past(link_rst) && !$past(rst))
        |-> ($past(!bclk_lvl && !sync_lvl && !sdo_lvl) && $past(rise_cnt) >= K_MIN));

    a_r9_order: assert property (@(posedge clk) disable iff (rst)
        dock_rst_n |-> !dock_en_n);
endmodule

bind dock_seq dock_seq_chk #(.MIN_ISO(MIN_ISO)) chk_i (
    .clk(clk), .rst(rst), .link_rst(link_rst), .bclk_lvl(bclk_lvl),
    .sync_lvl(sync_lvl), .sdo_lvl(sdo_lvl), .attach_o(attach_o),
    .mate_o(mate_o), .dock_en_n(dock_en_n), .dock_rst_n(dock_rst_n)
);

// File: tb/dock_seq_tb_top.sv
`timescale 1ns/1ps
module dock_seq_tb_top;
    localparam int SETTLE  = 8;
    localparam int MIN_ISO = 4;

    logic clk = 1'b0;
    logic rst, link_rst, attach_wr, attach_wdata, bclk_lvl, sync_lvl, sdo_lvl;
    logic attach_o, mate_o, dock_en_n, dock_rst_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    dock_seq #(.SETTLE(SETTLE), .MIN_ISO(MIN_ISO)) dut_i (
        .clk(clk), .rst(rst), .link_rst(link_rst), .attach_wr(attach_wr),
        .attach_wdata(attach_wdata), .bclk_lvl(bclk_lvl), .sync_lvl(sync_lvl),
        .sdo_lvl(sdo_lvl), .attach_o(attach_o), .mate_o(mate_o),
        .dock_en_n(dock_en_n), .dock_rst_n(dock_rst_n)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic en_n, input logic rst_n, input logic mate);
        chk(req, "dock_en_n", dock_en_n, en_n);
        chk(req, "dock_rst_n", dock_rst_n, rst_n);
        chk(req, "mate", mate_o, mate);
    endtask

    task automatic write_attach(input logic v);
        attach_wr = 1'b1; attach_wdata = v;
        tick();
        attach_wr = 1'b0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Drive the docking sequence edge by edge; release expected on edge SETTLE (R4)
    task automatic dock_walk();
        for (int k = 1; k <= SETTLE; k++) begin
            bclk_lvl = 1'b1;
            tick();
            if (k < SETTLE) chk_out("R4", 1'b0, 1'b0, 1'b0);
            else            chk_out("R4", 1'b0, 1'b1, 1'b1);
            chk("R9", "order", dock_rst_n && dock_en_n, 1'b0);
            bclk_lvl = 1'b0;
            tick();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; link_rst = 1'b1; attach_wr = 1'b0; attach_wdata = 1'b0;
        bclk_lvl = 1'b0; sync_lvl = 1'b0; sdo_lvl = 1'b0;
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk_out("R1", 1'b1, 1'b0, 1'b0);
        chk("R1", "attach", attach_o, 1'b0);

        // R2: link reset held with attach set
        write_attach(1'b1);
        chk("R2", "attach", attach_o, 1'b1);
        for (int k = 0; k < 10; k++) begin
            bclk_lvl = 1'b1; tick();
            bclk_lvl = 1'b0; tick();
        end
        chk_out("R2", 1'b1, 1'b0, 1'b0);

        // R3: release link reset -> enable next clock
        link_rst = 1'b0;
        tick();
        chk_out("R3", 1'b0, 1'b0, 1'b0);
        dock_walk();

        // R5: attach cleared with bclk low -> no change until an edge
        write_attach(1'b0);
        tick(); tick();
        chk_out("R5", 1'b0, 1'b1, 1'b1);
        bclk_lvl = 1'b1;
        tick();
        chk_out("R5", 1'b0, 1'b0, 1'b1);
        bclk_lvl = 1'b0;
        tick();
        chk_out("R5", 1'b0, 1'b0, 1'b1);

        // R6: all-low windows before the minimum edge count do not isolate
        for (int k = 1; k < MIN_ISO; k++) begin
            bclk_lvl = 1'b1; tick();
            bclk_lvl = 1'b0; tick();
            chk_out("R6", 1'b0, 1'b0, 1'b1);
        end
        bclk_lvl = 1'b1;
        tick();
        chk_out("R6", 1'b0, 1'b0, 1'b1);

        // R7: re-attach during undock
        write_attach(1'b1);
        chk_out("R7", 1'b0, 1'b0, 1'b1);

        // R6: sweep level combinations {bclk,sync,sdo}; only 000 isolates
        for (int c = 7; c >= 1; c--) begin
            {bclk_lvl, sync_lvl, sdo_lvl} = 3'(c);
            tick();
            chk_out("R6", 1'b0, 1'b0, 1'b1);
        end
        {bclk_lvl, sync_lvl, sdo_lvl} = 3'b000;
        tick();
        chk_out("R6", 1'b1, 1'b0, 1'b0);
        tick();
        chk_out("R7", 1'b0, 1'b0, 1'b0);
        dock_walk();

        // R8: link reset while docked
        link_rst = 1'b1;
        tick();
        chk_out("R8", 1'b1, 1'b0, 1'b0);
        link_rst = 1'b0;
        tick();
        chk_out("R3", 1'b0, 1'b0, 1'b0);

        // R8: link reset in the middle of the settle wait
        bclk_lvl = 1'b1; tick();
        bclk_lvl = 1'b0; tick();
        link_rst = 1'b1;
        tick();
        chk_out("R8", 1'b1, 1'b0, 1'b0);
        link_rst = 1'b0;
        tick();
        dock_walk();

        // R1: platform reset while docked
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk_out("R1", 1'b1, 1'b0, 1'b0);
        chk("R1", "attach", attach_o, 1'b0);
        tick();
        chk_out("R1", 1'b1, 1'b0, 1'b0);

        done = 1;
        summary();
        $finish;
    end
endmodule